// File: doc/BRIEF.md
# Compare-Match Periodic Interrupt Timer

This block raises periodic interrupt requests from two counter chains. Each chain has a prescaling up-counter that counts from zero to a programmed limit and then wraps. On each wrap, the chain's free-running counter advances by one. Four compare registers watch the free-running counters. Each compare is bound to one chain. When a compare matches its chain, the block sets that compare's flag and adds a per-compare step to the compare value, so the next match comes one step later without software help.

Software drives the block through a word-addressed register interface. It starts and stops the chains, binds compares to chains, loads the counters, compares and steps, enables interrupts, and clears flags by writing 1. There is one interrupt line per compare. A combined line covers compares 1 to 3 and fires a one-cycle pulse when their enabled flags go from none to some. The line therefore fires again only after software has cleared the flags that are pending.

Top module: `cmp_irq_timer`

Register word map (byte address = 4 × word): 0 RUN, 1 BIND, 2 IEN, 3 FLAG, 4/5 PRE chain 0/1, 6/7 PCNT chain 0/1, 8/9 FRC chain 0/1, 16+2i CMP i, 17+2i STEP i. Every register is 32 bits wide and reads back through `rd_data`.

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `irq_comb` is 0.
- R2: RUN bit c enables chain c (bit 0 is chain 0, bit 1 is chain 1). Writing 0 to RUN stops both chains. A stopped chain holds its PCNT and FRC values.
- R3: On a running chain, PCNT increments each cycle while it is below PRE. When PCNT is at or above PRE, it returns to 0 and FRC increments, so FRC advances once every PRE+1 cycles.
- R4: BIND bit 4·i selects the chain that compare i watches: 0 selects chain 0 and 1 selects chain 1. For example, 0x10 binds compare 1 to chain 1 and compare 0 to chain 0.
- R5: When a chain's FRC advances to a value equal to CMP i of a compare bound to that chain, FLAG bit i sets on that edge and CMP i becomes CMP i + STEP i. With a step of 1, the compare stays one count ahead.
- R6: A flag sets whether or not its enable is on. `irq[i]` is FLAG bit i AND IEN bit i.
- R7: Writing FLAG clears each bit written as 1. Bits written as 0 are unchanged.
- R8: If a match and a clearing write to the same flag occur in the same cycle, the flag ends up set.
- R9: `irq_comb` is high for exactly one cycle when the OR of enabled flags 1 to 3 rises. It does not pulse again until that OR has fallen to 0.
- R10: Bus writes to PCNT and FRC load those counters directly. A bus write takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 4 | Per-compare interrupt request |
| irq_comb | output | 1 | Combined pulse for compares 1 to 3 |

## Verification
The hardest situation to reach is a clearing write to a flag that lands on the same clock edge as that flag's match (R8). The bench reaches it by loading a compare five counts ahead of a chain with no prescale. It then counts whole cycles from the edge where the run bit takes effect and times the FLAG write to commit on the matching edge. The re-arm of the combined pulse is also tested: after its flags are cleared, new flags are raised with the enables off, and then the enables are turned on.

// File: rtl/cmp_irq_timer.sv
module cmp_irq_timer #(
  parameter int W    = 32,
  parameter int NCMP = 4,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    rd_data,
  output logic [NCMP-1:0] irq,
  output logic            irq_comb
);
  localparam int WA     = AW - 2;
  localparam int A_RUN  = 0;
  localparam int A_BIND = 1;
  localparam int A_IEN  = 2;
  localparam int A_FLAG = 3;
  localparam int A_PRE  = 4;
  localparam int A_PCNT = 6;
  localparam int A_FRC  = 8;
  localparam int A_CMP  = 16;

  logic [1:0]      run;
  logic [W-1:0]    bind_r, ien;
  logic [NCMP-1:0] flag;
  logic [W-1:0]    pre [2];
  logic [W-1:0]    pcnt[2];
  logic [W-1:0]    frc [2];
  logic [W-1:0]    cmp [NCMP];
  logic [W-1:0]    step[NCMP];
  logic [1:0]      tick;
  logic [NCMP-1:0] match;
  logic            comb_q, any_hi;
  logic [WA-1:0]   wsel;

  assign wsel = addr[AW-1:2];

  for (genvar c = 0; c < 2; c++) begin : g_tick
    assign tick[c] = run[c] && (pcnt[c] >= pre[c]);
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_match
    logic s;
    assign s        = bind_r[4*i];
    assign match[i] = tick[s] && ((frc[s] + W'(1)) == cmp[i]);
  end

  assign irq      = flag & ien[NCMP-1:0];
  assign any_hi   = |irq[NCMP-1:1];
  assign irq_comb = any_hi && !comb_q;

  function automatic logic hit(input int w);
    return wr_en && (wsel == WA'(w));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= '0;
      bind_r <= '0;
      ien    <= '0;
      flag   <= '0;
      comb_q <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        pre[c]  <= '0;
        pcnt[c] <= '0;
        frc[c]  <= '0;
      end
      for (int i = 0; i < NCMP; i++) begin
        cmp[i]  <= '0;
        step[i] <= '0;
      end
    end else begin
      comb_q <= any_hi;
      if (hit(A_RUN))  run    <= wdata[1:0];
      if (hit(A_BIND)) bind_r <= wdata;
      if (hit(A_IEN))  ien    <= wdata;
      for (int c = 0; c < 2; c++) begin
        if (hit(A_PRE + c)) pre[c] <= wdata;
        if (hit(A_PCNT + c))  pcnt[c] <= wdata;
        else if (tick[c])     pcnt[c] <= '0;
        else if (run[c])      pcnt[c] <= pcnt[c] + W'(1);
        if (hit(A_FRC + c))   frc[c] <= wdata;
        else if (tick[c])     frc[c] <= frc[c] + W'(1);
      end
      for (int i = 0; i < NCMP; i++) begin
        if (hit(A_CMP + 2*i))       cmp[i] <= wdata;
        else if (match[i])          cmp[i] <= cmp[i] + step[i];
        if (hit(A_CMP + 2*i + 1))   step[i] <= wdata;
        if (match[i])               flag[i] <= 1'b1;
        else if (hit(A_FLAG) && wdata[i]) flag[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (wsel == WA'(A_RUN))  rd_data = W'(run);
    if (wsel == WA'(A_BIND)) rd_data = bind_r;
    if (wsel == WA'(A_IEN))  rd_data = ien;
    if (wsel == WA'(A_FLAG)) rd_data = W'(flag);
    for (int c = 0; c < 2; c++) begin
      if (wsel == WA'(A_PRE + c))  rd_data = pre[c];
      if (wsel == WA'(A_PCNT + c)) rd_data = pcnt[c];
      if (wsel == WA'(A_FRC + c))  rd_data = frc[c];
    end
    for (int i = 0; i < NCMP; i++) begin
      if (wsel == WA'(A_CMP + 2*i))     rd_data = cmp[i];
      if (wsel == WA'(A_CMP + 2*i + 1)) rd_data = step[i];
    end
  end
endmodule

module cmp_irq_timer_chk #(
  parameter int W    = 32,
  parameter int NCMP = 4,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [W-1:0]    wdata,
  input logic [NCMP-1:0] irq,
  input logic            irq_comb,
  input logic [NCMP-1:0] flag,
  input logic            run0,
  input logic [W-1:0]    frc0
);
  logic [AW-3:0] ws;
  assign ws = addr[AW-1:2];

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_comb |=> !irq_comb);

  a_r6_comb_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_comb |-> (|irq[NCMP-1:1]));

  a_r7_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ws == 3 && wdata[NCMP-1:0] == '0) |=> ((flag & $past(flag)) == $past(flag)));

  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !(wr_en && ws == 8)) |=> $stable(frc0));

  a_r10_frc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ws == 8) |=> (frc0 == $past(wdata)));
endmodule

bind cmp_irq_timer cmp_irq_timer_chk #(.W(W), .NCMP(NCMP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .irq_comb(irq_comb), .flag(flag), .run0(run[0]), .frc0(frc[0])
);

// File: tb/tb_cmp_irq_timer.sv
module tb_cmp_irq_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq;
  logic        irq_comb;

  always #2 clk = ~clk;

  cmp_irq_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .irq(irq), .irq_comb(irq_comb));

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [7:0] RUN = 8'h00, BIND = 8'h04, IEN = 8'h08, FLAG = 8'h0C,
    PRE0 = 8'h10, PRE1 = 8'h14, PCNT0 = 8'h18, PCNT1 = 8'h1C,
    FRC0 = 8'h20, FRC1 = 8'h24, CMP0 = 8'h40, STEP0 = 8'h44,
    CMP1 = 8'h48, STEP1 = 8'h4C, CMP2 = 8'h50, STEP2 = 8'h54;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? rd_data : (it.kind == 1) ? {28'd0, irq} : {31'd0, irq_comb};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic chk(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic run_for(input logic [31:0] mask, input int k);
    wr(RUN, mask);
    repeat (k - 2) @(posedge clk);
    wr(RUN, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    chk(0, RUN, 0, "R1 run reg");
    chk(0, FRC0, 0, "R1 frc0");
    chk(0, CMP1, 0, "R1 cmp1");
    chk(0, FLAG, 0, "R1 flag");
    chk(1, 0, 0, "R1 irq");
    chk(2, 0, 0, "R1 irq_comb");

    wr(FRC1, 5); wr(PCNT0, 3);
    chk(0, FRC1, 5, "R10 frc1 load");
    chk(0, PCNT0, 3, "R10 pcnt0 load");
    chk(0, PCNT0, 3, "R2 stopped pcnt0 holds");

    wr(PRE0, 2); wr(FRC0, 0); wr(PCNT0, 0);
    run_for(1, 7);
    chk(0, FRC0, 2, "R3 frc0 after 7 cycles pre=2");
    chk(0, PCNT0, 1, "R3 pcnt0 after 7 cycles");
    chk(0, FRC1, 5, "R2 chain1 not started");

    wr(FRC1, 0); wr(BIND, 32'h10); wr(CMP1, 3); wr(STEP1, 4);
    run_for(2, 10);
    chk(0, FRC1, 10, "R3 frc1 pre=0");
    chk(0, CMP1, 11, "R5 cmp1 stepped twice");
    chk(0, FLAG, 2, "R6 flag set while disabled");
    chk(1, 0, 0, "R6 irq off while disabled");

    wr(FLAG, 0);
    chk(0, FLAG, 2, "R7 write 0 keeps flag");
    wr(FLAG, 2);
    chk(0, FLAG, 0, "R7 write 1 clears");

    wr(BIND, 32'h110); wr(CMP2, 12); wr(STEP2, 1);
    run_for(2, 3);
    chk(0, FLAG, 6, "R4 cmp2 bound to chain1");
    chk(0, CMP2, 14, "R5 step 1 stays ahead");
    chk(0, CMP1, 15, "R5 cmp1 third match");

    wr(IEN, 2);
    chk(2, 0, 1, "R9 pulse on rise");
    chk(2, 0, 0, "R9 pulse one cycle");
    chk(1, 0, 4'b0010, "R6 irq and");
    wr(IEN, 6);
    chk(2, 0, 0, "R9 no pulse while pending");
    chk(1, 0, 4'b0110, "R6 irq two lines");
    wr(FLAG, 2);
    chk(1, 0, 4'b0100, "R7 clear one flag");
    chk(2, 0, 0, "R9 no pulse on partial clear");

    wr(IEN, 0); wr(FLAG, 4);
    chk(0, FLAG, 0, "R7 cleared all");
    run_for(2, 2);
    chk(0, FLAG, 6, "R5 new matches");
    wr(IEN, 2);
    chk(2, 0, 1, "R9 pulse again after clear");

    wr(IEN, 0); wr(FLAG, 32'hF);
    wr(PRE0, 0); wr(FRC0, 0); wr(PCNT0, 0); wr(CMP0, 5); wr(STEP0, 100);
    wr(RUN, 1);
    repeat (3) @(posedge clk);
    wr(FLAG, 1);
    wr(RUN, 0);
    chk(0, FLAG, 1, "R8 set beats clear");
    wr(FLAG, 1);
    chk(0, FLAG, 0, "R7 clear without match");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule